// File: doc/BRIEF.md
# Disk Controller Command and Result Phase Sequencer

This block is the host-side phase engine of a floppy disk controller. The host writes command bytes to a data register and polls a main status register to see which phase the sequencer is in. The sequencer decodes each opcode. Configure and mode commands take parameter bytes and need no result. A small range of other opcodes is accepted as a generic command that finishes at once. Any other opcode produces a single invalid-command status byte in the result phase.

The block also holds the FIFO configuration: enable, threshold, pretrack, write-disable, read-disable and burst. A lock command decides whether these fields survive a software reset. The new lock value takes effect only when the host reads the lock command's result byte. A reset that arrives before that read cancels the update. A hardware reset always returns every field and the lock bit to their defaults.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After a hardware reset the status register reads 80h, the lock bit is 0 and every FIFO field is 0 (FIFO disabled, threshold 0, pretrack 0, write-disable 0, read-disable 0, burst 0).
- R2: An opcode written in the command phase that is not 01h, 13h, 02h to 0Fh, or 14h/94h (bits 6:0 = 14h) moves the sequencer to the result phase with exactly one result byte, equal to 80h.
- R3: The status register reads 80h in the command phase, 90h while parameter bytes are still expected, and D0h (bits 7 and 6 both 1) while a result byte waits to be read.
- R4: In the result phase, data-register writes are ignored. A new opcode is accepted only after the result byte has been read.
- R5: A lock command (bits 6:0 = 14h) carries the new lock value in bit 7. Its result byte is that value placed in bit 4, with all other bits 0. The lock bit changes only on the cycle in which that result byte is read.
- R6: A software or hardware reset between the lock command write and its result read cancels the lock update and returns the sequencer to the command phase.
- R7: A software reset with the lock bit at 1 leaves all six FIFO fields unchanged.
- R8: A software reset with the lock bit at 0 returns all six FIFO fields to their defaults.
- R9: A hardware reset clears the lock bit and all FIFO fields, whatever the lock state.
- R10: Configure (13h) takes two parameter bytes. In the first, bit 5 is FIFO enable (1 = enabled) and bits 3:0 are the threshold. The second is the pretrack value. Mode (01h) takes one parameter byte: bit 0 is write-disable, bit 1 is read-disable and bit 2 is burst. Both commands return to the command phase after their last parameter and produce no result byte.
- R11: Opcodes 02h to 0Fh complete at once. The status register stays at 80h, and a data read returns 00h.
- R12: Once the result byte has been read, the status register returns to 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| soft_rst | input | 1 | Software reset pulse, synchronous, active high |
| cs | input | 1 | Register port select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 1 | 0 = status register, 1 = data register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| lock_state | output | 1 | Current lock bit |
| fifo_en | output | 1 | FIFO enable |
| fifo_thr | output | 4 | FIFO threshold |
| pretrk | output | 8 | Pretrack value |
| fifo_wdis | output | 1 | FIFO write-transfer disable |
| fifo_rdis | output | 1 | FIFO read-transfer disable |
| fifo_burst | output | 1 | Burst mode |

## Verification
The opcode decode is driven with a parameterised configure, a mode command, a generic opcode, an out-of-range opcode and both lock values. This separates the four decode outcomes by their status sequence and result bytes. Software resets are applied with the lock bit at 0, with it at 1, and between a lock write and its result read. These three cases separate keeping the fields, restoring the defaults and cancelling the lock update. Hardware resets with a lock pending and with the lock already set show that the hardware path overrides the lock. Writes during a pending result show that the result byte and phase stay intact.

// File: rtl/fdc_cmd_pkg.sv
package fdc_cmd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PARAM  = 2'd1,
    PH_RESULT = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    PK_CFG   = 2'd0,
    PK_MODE  = 2'd1,
    PK_OTHER = 2'd2
  } pend_e;

  localparam logic [6:0] OPC_LOCK    = 7'h14;
  localparam logic [7:0] OPC_CFG     = 8'h13;
  localparam logic [7:0] OPC_MODE    = 8'h01;
  localparam logic [7:0] OPC_GEN_LO  = 8'h02;
  localparam logic [7:0] OPC_GEN_HI  = 8'h0F;
  localparam logic [7:0] ST0_BADCMD  = 8'h80;

  localparam logic [7:0] MSR_IDLE    = 8'h80;
  localparam logic [7:0] MSR_PARAM   = 8'h90;
  localparam logic [7:0] MSR_RESULT  = 8'hD0;

  localparam int CFG_NPARAM  = 2;
  localparam int MODE_NPARAM = 1;

  function automatic logic is_generic(input logic [7:0] op);
    return (op >= OPC_GEN_LO) && (op <= OPC_GEN_HI);
  endfunction

endpackage

// File: rtl/fdc_host_port.sv
module fdc_host_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] msr,
  input  logic [DATA_W-1:0] res_byte,
  input  logic              res_valid,
  output logic              rd_data_stb,
  output logic              wr_data_stb,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rd_data_stb = cs && rd && addr;
    wr_data_stb = cs && wr && addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (cs && rd) begin
      if (addr) rdata <= res_valid ? res_byte : '0;
      else      rdata <= msr;
    end
  end

endmodule

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
  import fdc_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] msr,
  output logic [DATA_W-1:0] res_byte,
  output logic              res_valid,
  output logic              cfg_we,
  output logic [DATA_W-1:0] cfg_p1,
  output logic [DATA_W-1:0] cfg_p2,
  output logic              mode_we,
  output logic [DATA_W-1:0] mode_p,
  output logic              lock_we,
  output logic              lock_val
);

  localparam int CNT_W = $clog2(CFG_NPARAM + 1);

  phase_e            phase_q;
  pend_e             pend_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] p1_q;
  logic [DATA_W-1:0] res_q;
  logic              lk_pend_q;
  logic              lk_val_q;

  always_comb begin
    cfg_we   = wr_stb && (phase_q == PH_PARAM) && (pend_q == PK_CFG)
               && (left_q == CNT_W'(1)) && !soft_rst;
    mode_we  = wr_stb && (phase_q == PH_PARAM) && (pend_q == PK_MODE) && !soft_rst;
    lock_we  = rd_stb && (phase_q == PH_RESULT) && lk_pend_q && !soft_rst;
    lock_val = lk_val_q;
    cfg_p1   = p1_q;
    cfg_p2   = wdata;
    mode_p   = wdata;
    res_byte = res_q;
    res_valid = (phase_q == PH_RESULT);
    case (phase_q)
      PH_PARAM:  msr = MSR_PARAM;
      PH_RESULT: msr = MSR_RESULT;
      default:   msr = MSR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      phase_q   <= PH_IDLE;
      pend_q    <= PK_OTHER;
      left_q    <= '0;
      p1_q      <= '0;
      res_q     <= '0;
      lk_pend_q <= 1'b0;
      lk_val_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (wr_stb) begin
            if (wdata[6:0] == OPC_LOCK) begin
              phase_q   <= PH_RESULT;
              res_q     <= {3'b000, wdata[7], 4'b0000};
              lk_pend_q <= 1'b1;
              lk_val_q  <= wdata[7];
            end else if (wdata == OPC_CFG) begin
              phase_q <= PH_PARAM;
              pend_q  <= PK_CFG;
              left_q  <= CNT_W'(CFG_NPARAM);
            end else if (wdata == OPC_MODE) begin
              phase_q <= PH_PARAM;
              pend_q  <= PK_MODE;
              left_q  <= CNT_W'(MODE_NPARAM);
            end else if (is_generic(wdata)) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q   <= PH_RESULT;
              res_q     <= ST0_BADCMD;
              lk_pend_q <= 1'b0;
            end
          end
        end
        PH_PARAM: begin
          if (wr_stb) begin
            if ((pend_q == PK_CFG) && (left_q == CNT_W'(CFG_NPARAM))) p1_q <= wdata;
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              phase_q <= PH_IDLE;
              pend_q  <= PK_OTHER;
            end
          end
        end
        PH_RESULT: begin
          if (rd_stb) begin
            phase_q   <= PH_IDLE;
            lk_pend_q <= 1'b0;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_BAD_OPCODE_RESULT: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (wr_stb && phase_q == PH_IDLE && wdata[6:0] != OPC_LOCK && wdata != OPC_CFG
     && wdata != OPC_MODE && !is_generic(wdata))
    |=> (phase_q == PH_RESULT && res_q == ST0_BADCMD && !lk_pend_q)); // R2

  AST_SOFT_CANCELS_LOCK: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (phase_q == PH_IDLE && !lk_pend_q)); // R6

  AST_RESULT_READ_ENDS: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (rd_stb && phase_q == PH_RESULT) |=> (phase_q == PH_IDLE)); // R12

  AST_RESULT_HOLDS_ON_WRITE: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (phase_q == PH_RESULT && !rd_stb) |=> (phase_q == PH_RESULT && $stable(res_q))); // R4

endmodule

// File: rtl/fdc_fifo_cfg.sv
module fdc_fifo_cfg #(
  parameter int          DATA_W      = 8,
  parameter int          THR_W       = 4,
  parameter int          PRE_W       = 8,
  parameter logic        DEF_FIFO_EN = 1'b0,
  parameter int unsigned DEF_THR     = 0,
  parameter int unsigned DEF_PRE     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_p1,
  input  logic [DATA_W-1:0] cfg_p2,
  input  logic              mode_we,
  input  logic [DATA_W-1:0] mode_p,
  input  logic              lock_we,
  input  logic              lock_val,
  output logic              lock_q,
  output logic              fifo_en_q,
  output logic [THR_W-1:0]  thr_q,
  output logic [PRE_W-1:0]  pre_q,
  output logic              wdis_q,
  output logic              rdis_q,
  output logic              burst_q
);

  localparam int FEN_BIT = 5;
  localparam logic [THR_W-1:0] THR_RST = THR_W'(DEF_THR);
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(DEF_PRE);

  logic unused_bits;
  assign unused_bits = ^{cfg_p1, cfg_p2, mode_p};

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= 1'b0;
      fifo_en_q <= DEF_FIFO_EN;
      thr_q     <= THR_RST;
      pre_q     <= PRE_RST;
      wdis_q    <= 1'b0;
      rdis_q    <= 1'b0;
      burst_q   <= 1'b0;
    end else if (soft_rst) begin
      if (!lock_q) begin
        fifo_en_q <= DEF_FIFO_EN;
        thr_q     <= THR_RST;
        pre_q     <= PRE_RST;
        wdis_q    <= 1'b0;
        rdis_q    <= 1'b0;
        burst_q   <= 1'b0;
      end
    end else begin
      if (cfg_we) begin
        fifo_en_q <= cfg_p1[FEN_BIT];
        thr_q     <= cfg_p1[THR_W-1:0];
        pre_q     <= cfg_p2[PRE_W-1:0];
      end
      if (mode_we) begin
        wdis_q  <= mode_p[0];
        rdis_q  <= mode_p[1];
        burst_q <= mode_p[2];
      end
      if (lock_we) lock_q <= lock_val;
    end
  end

  AST_LOCK_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !lock_we |=> $stable(lock_q)); // R5

  AST_LOCKED_FIELDS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && lock_q) |=> ($stable(fifo_en_q) && $stable(thr_q) && $stable(pre_q)
                              && $stable(wdis_q) && $stable(rdis_q) && $stable(burst_q))); // R7

  AST_UNLOCKED_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !lock_q) |=> (fifo_en_q == DEF_FIFO_EN && thr_q == THR_RST && pre_q == PRE_RST
                               && !wdis_q && !rdis_q && !burst_q)); // R8

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq #(
  parameter int          DATA_W      = 8,
  parameter int          THR_W       = 4,
  parameter int          PRE_W       = 8,
  parameter logic        DEF_FIFO_EN = 1'b0,
  parameter int unsigned DEF_THR     = 0,
  parameter int unsigned DEF_PRE     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              lock_state,
  output logic              fifo_en,
  output logic [THR_W-1:0]  fifo_thr,
  output logic [PRE_W-1:0]  pretrk,
  output logic              fifo_wdis,
  output logic              fifo_rdis,
  output logic              fifo_burst
);

  logic              rd_data_stb, wr_data_stb;
  logic [DATA_W-1:0] msr, res_byte, cfg_p1, cfg_p2, mode_p;
  logic              res_valid, cfg_we, mode_we, lock_we, lock_val;

  fdc_host_port #(.DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .cs          (cs),
    .rd          (rd),
    .wr          (wr),
    .addr        (addr),
    .msr         (msr),
    .res_byte    (res_byte),
    .res_valid   (res_valid),
    .rd_data_stb (rd_data_stb),
    .wr_data_stb (wr_data_stb),
    .rdata       (rdata)
  );

  fdc_phase_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .wr_stb    (wr_data_stb),
    .rd_stb    (rd_data_stb),
    .wdata     (wdata),
    .msr       (msr),
    .res_byte  (res_byte),
    .res_valid (res_valid),
    .cfg_we    (cfg_we),
    .cfg_p1    (cfg_p1),
    .cfg_p2    (cfg_p2),
    .mode_we   (mode_we),
    .mode_p    (mode_p),
    .lock_we   (lock_we),
    .lock_val  (lock_val)
  );

  fdc_fifo_cfg #(
    .DATA_W      (DATA_W),
    .THR_W       (THR_W),
    .PRE_W       (PRE_W),
    .DEF_FIFO_EN (DEF_FIFO_EN),
    .DEF_THR     (DEF_THR),
    .DEF_PRE     (DEF_PRE)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .cfg_we    (cfg_we),
    .cfg_p1    (cfg_p1),
    .cfg_p2    (cfg_p2),
    .mode_we   (mode_we),
    .mode_p    (mode_p),
    .lock_we   (lock_we),
    .lock_val  (lock_val),
    .lock_q    (lock_state),
    .fifo_en_q (fifo_en),
    .thr_q     (fifo_thr),
    .pre_q     (pretrk),
    .wdis_q    (fifo_wdis),
    .rdis_q    (fifo_rdis),
    .burst_q   (fifo_burst)
  );

  AST_HW_RESET_CLEARS: assert property (@(posedge clk)
    $fell(rst) |-> (!lock_state && !fifo_en && fifo_thr == THR_W'(DEF_THR) && !fifo_burst)); // R9

endmodule

// File: tb/sim_fdc_cmd_seq.sv
module sim_fdc_cmd_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       lock_state, fifo_en, fifo_wdis, fifo_rdis, fifo_burst;
  logic [3:0] fifo_thr;
  logic [7:0] pretrk;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  fdc_cmd_seq u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .lock_state(lock_state),
    .fifo_en(fifo_en), .fifo_thr(fifo_thr), .pretrk(pretrk),
    .fifo_wdis(fifo_wdis), .fifo_rdis(fifo_rdis), .fifo_burst(fifo_burst)
  );

  // monitor: each read access yields one scoreboard comparison
  always @(posedge clk) begin
    if (cs && rd) begin
      #1;
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read with no expected item, got %02h", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read got %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_exp(input logic a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic pulse(input logic hard);
    @(negedge clk);
    if (hard) rst = 1'b1; else soft_rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic chk_cfg(input string t, input logic [15:0] exp);
    chk(t, {fifo_en, fifo_thr, pretrk, fifo_wdis, fifo_rdis, fifo_burst}, exp);
  endtask

  task automatic program_all;
    wr_reg(1'b1, 8'h13);
    rd_exp(1'b0, 8'h90, "R3 param phase");
    wr_reg(1'b1, 8'h2A);
    wr_reg(1'b1, 8'h55);
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b1, 8'h07);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not end, got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_exp(1'b0, 8'h80, "R1 status after reset");
    chk("R1 lock after reset", lock_state, 0);
    chk_cfg("R1 fifo defaults", 16'h0000);

    // R10 configure and mode
    program_all();
    chk_cfg("R10 configure+mode fields", {1'b1, 4'hA, 8'h55, 3'b111});
    rd_exp(1'b0, 8'h80, "R10 back to command phase");

    // R11 generic opcode
    wr_reg(1'b1, 8'h05);
    rd_exp(1'b0, 8'h80, "R11 generic status");
    rd_exp(1'b1, 8'h00, "R11 generic no result");

    // R2 invalid opcode, R4 write ignored, R12 return
    wr_reg(1'b1, 8'h7F);
    rd_exp(1'b0, 8'hD0, "R3 result pending");
    wr_reg(1'b1, 8'h13);
    rd_exp(1'b0, 8'hD0, "R4 write ignored in result");
    rd_exp(1'b1, 8'h80, "R2 invalid status byte");
    rd_exp(1'b0, 8'h80, "R12 status after result");

    // R8 unlocked soft reset
    pulse(1'b0);
    chk_cfg("R8 unlocked soft reset defaults", 16'h0000);

    // R5 lock set commits on read
    program_all();
    wr_reg(1'b1, 8'h94);
    chk("R5 lock not yet committed", lock_state, 0);
    rd_exp(1'b0, 8'hD0, "R5 lock result pending");
    rd_exp(1'b1, 8'h10, "R5 lock result byte");
    chk("R5 lock committed", lock_state, 1);

    // R7 locked soft reset keeps fields
    pulse(1'b0);
    chk_cfg("R7 locked soft reset keeps", {1'b1, 4'hA, 8'h55, 3'b111});
    chk("R7 lock kept", lock_state, 1);

    // R6 soft reset cancels pending unlock
    wr_reg(1'b1, 8'h14);
    pulse(1'b0);
    chk("R6 soft cancel lock", lock_state, 1);
    rd_exp(1'b0, 8'h80, "R6 status after cancel");
    rd_exp(1'b1, 8'h00, "R6 no result after cancel");

    // R5 clearing lock
    wr_reg(1'b1, 8'h14);
    rd_exp(1'b1, 8'h00, "R5 unlock result byte");
    chk("R5 lock cleared", lock_state, 0);

    // R6 hardware reset cancels pending lock
    wr_reg(1'b1, 8'h94);
    pulse(1'b1);
    chk("R6 hw cancel lock", lock_state, 0);
    rd_exp(1'b0, 8'h80, "R6 status after hw reset");

    // R9 hardware reset overrides lock
    program_all();
    wr_reg(1'b1, 8'h94);
    rd_exp(1'b1, 8'h10, "R9 lock set before hw reset");
    chk("R9 lock set", lock_state, 1);
    pulse(1'b1);
    chk("R9 lock cleared by hw reset", lock_state, 0);
    chk_cfg("R9 fields cleared by hw reset", 16'h0000);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d reads missing expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule